// File: doc/BRIEF.md
# Split-Phase Data-Strobe Line Transmitter

This block turns parallel characters into a two-wire data-strobe signal. One bit leaves on every clock edge. A bit sent while the clock is high is called an even bit, and a bit sent while the clock is low is called an odd bit. Each clock cycle therefore carries one even/odd pair. Both bits of the pair are prepared together in the rising-edge clock domain, so the logic runs at half the line bit rate.

The strobe line is not toggled serially. Each phase computes its strobe from its own data bit and a constant term that matches the clock level of that phase: 1 for the high phase and 0 for the low phase. As a result, data XOR strobe follows the clock, and exactly one of the two wires changes at every bit boundary. A double-data-rate stage for each wire merges the two half-rate phases. Data and strobe pass through the same number of flops, so both wires settle on the same edge.

Characters enter through a valid/ready handshake. A character is transferred only on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` rises while the current character still has its last pair to send, so a producer that keeps `in_valid` high gets a gap-free stream. While `in_ready` is low, a waiting producer must hold its character stable. When nothing is queued, the wires stop changing and hold their last value.

Top module: `ds_split_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released with no character accepted, `ds_data` and `ds_strobe` are both 0 and `in_ready` is 1.
- R2: A character is taken only on a rising edge with `in_valid` and `in_ready` both high. `in_ready` is 0 while more than two bits of the current character remain to be sent. `in_data` has no effect while `in_valid` is low.
- R3: Bits leave least significant first. Bit 2k is driven during the high clock phase and bit 2k+1 during the following low phase. Bit 0 of a character accepted at rising edge E appears in the high phase that follows the second rising edge after E.
- R4: For every bit sent, `ds_data` XOR `ds_strobe` equals 1 during the high phase and 0 during the low phase.
- R5: While bits are sent, exactly one of `ds_data` and `ds_strobe` changes at each clock edge. Neither wire changes when no bit is sent.
- R6: Characters accepted on consecutive ready edges produce a continuous stream with no idle half-cycle between them.
- R7: When no character is pending, both wires hold the values of the last odd bit (`ds_data` = `ds_strobe` = that bit) through both clock phases.
- R8: A character sent after any idle period starts without a double toggle and without a stale bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; both edges carry a bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer has a character on `in_data` |
| in_data | input | CHAR_W | Character to send, bit 0 first |
| in_ready | output | 1 | Transmitter can take a character on this edge |
| ds_data | output | 1 | Data wire |
| ds_strobe | output | 1 | Strobe wire |

## Verification
The in-module assertions check, at every rising edge, the per-pair phase code, the single change from the previous odd bit into the next even bit, the idle hold, and the fact that an accepted character always reaches the output pipeline on the next edge. Some behaviour can only be seen by sampling the wires in both phases in the bench scenarios: bit order, latency, continuity across consecutive characters, and the absence of stray bits while `in_valid` is low. Those scenarios decode every half-cycle with a scoreboard.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

  typedef struct packed {
    logic d;
    logic s;
  } ds_line_t;

  // Clock-level term for each phase: high phase carries 1, low phase carries 0.
  localparam logic HIGH_PHASE_TERM = 1'b1;
  localparam logic LOW_PHASE_TERM  = 1'b0;

  function automatic ds_line_t encode_bit(input logic bit_d, input logic term);
    ds_line_t l;
    l.d = bit_d;
    l.s = bit_d ^ term;
    return l;
  endfunction

endpackage

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              pair_valid,
  output logic              pair_even,
  output logic              pair_odd
);
  localparam int CW = $clog2(CHAR_W + 1);
  localparam logic [CW-1:0] PAIR = CW'(2);
  localparam logic [CW-1:0] FULL = CW'(CHAR_W);

  logic [CHAR_W-1:0] shreg;
  logic [CW-1:0]     left;
  logic              take;

  // Ready while at most one pair remains: the new character follows without a gap.
  assign in_ready = (left <= PAIR);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      left       <= '0;
      pair_valid <= 1'b0;
      pair_even  <= 1'b0;
      pair_odd   <= 1'b0;
    end else begin
      pair_valid <= (left >= PAIR);
      pair_even  <= shreg[0];
      pair_odd   <= shreg[1];
      if (take) begin
        shreg <= in_data;
        left  <= FULL;
      end else if (left >= PAIR) begin
        shreg <= shreg >> 2;
        left  <= left - PAIR;
      end
    end
  end

  // R6: an accepted character always feeds a pair on the next edge
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (left >= PAIR));

  // R2: the remaining count never exceeds one character
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    left <= FULL);

endmodule

// File: rtl/ds_tx_strobe_enc.sv
module ds_tx_strobe_enc
  import ds_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pair_valid,
  input  logic     pair_even,
  input  logic     pair_odd,
  output ds_line_t rise_line,
  output ds_line_t fall_line
);
  ds_line_t even_next, odd_next;

  always_comb begin
    if (pair_valid) begin
      even_next = encode_bit(pair_even, HIGH_PHASE_TERM);
      odd_next  = encode_bit(pair_odd,  LOW_PHASE_TERM);
    end else begin
      // Idle: both phases repeat the last odd value so the wires stay still.
      even_next = fall_line;
      odd_next  = fall_line;
    end
  end

  // Data and strobe share this register level (path equalization).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_line <= '0;
      fall_line <= '0;
    end else begin
      rise_line <= even_next;
      fall_line <= odd_next;
    end
  end

  // R4: phase code of a delivered pair
  a_r4_phase_code: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> ((rise_line.d ^ rise_line.s) && !(fall_line.d ^ fall_line.s)));

  // R5: step from previous odd bit into new even bit flips exactly one wire
  a_r5_one_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> ((rise_line.d != $past(fall_line.d)) != (rise_line.s != $past(fall_line.s))));

  // R7: idle holds the last odd value in both phases
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |=> (rise_line == fall_line) && $stable(fall_line));

endmodule

// File: rtl/ds_tx_ddr_cell.sv
module ds_tx_ddr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic d_rise,
  input  logic d_fall,
  output logic q
);
  logic fall_q;

  // Falling-edge retime of the low-phase value, as an output DDR flop would.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= d_fall;
  end

  // Clock-level selection models the DDR output mux.
  assign q = clk ? d_rise : fall_q;

endmodule

// File: rtl/ds_split_tx.sv
module ds_split_tx
  import ds_tx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              ds_data,
  output logic              ds_strobe
);
  localparam int LANES = 2;

  initial begin
    if (CHAR_W < 2 || (CHAR_W % 2) != 0)
      $error("CHAR_W must be even and at least 2");
  end

  logic     pv, pe, po;
  ds_line_t rise_line, fall_line;
  logic [LANES-1:0] lane_rise, lane_fall, lane_q;

  ds_tx_serializer #(.CHAR_W(CHAR_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pair_valid(pv), .pair_even(pe), .pair_odd(po)
  );

  ds_tx_strobe_enc u_enc (
    .clk(clk), .rst_n(rst_n), .pair_valid(pv), .pair_even(pe), .pair_odd(po),
    .rise_line(rise_line), .fall_line(fall_line)
  );

  assign lane_rise = {rise_line.s, rise_line.d};
  assign lane_fall = {fall_line.s, fall_line.d};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ds_tx_ddr_cell u_ddr (
      .clk(clk), .rst_n(rst_n), .d_rise(lane_rise[g]), .d_fall(lane_fall[g]),
      .q(lane_q[g])
    );
  end

  assign ds_data   = lane_q[0];
  assign ds_strobe = lane_q[1];

  // R1: reset leaves the wires low and the input open
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!ds_data && !ds_strobe && in_ready));

endmodule

// File: tb/ds_split_tx_bench.sv
module ds_split_tx_bench;
  localparam int  W  = 8;
  localparam time CP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, ds_data, ds_strobe;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  logic prev_d = 1'b0, prev_s = 1'b0;
  int run_len = 0, last_run = 0, events = 0;
  time acc_time = 0, first_ev = 0;
  bit done = 0;

  ds_split_tx #(.CHAR_W(W)) u_ds_split_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ds_data(ds_data), .ds_strobe(ds_strobe)
  );

  always #(CP/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: decode each half-cycle and compare against the scoreboard.
  task automatic sample(input bit high);
    logic cd, cs;
    bit b;
    cd = ds_data; cs = ds_strobe;
    if ((cd ^ prev_d) && (cs ^ prev_s)) begin
      check(0, "R5 both wires changed", 2, 1);
    end else if ((cd ^ prev_d) || (cs ^ prev_s)) begin
      events++;
      if (first_ev == 0) first_ev = $time;
      check((cd ^ cs) == high, "R4 phase code", int'(cd ^ cs), int'(high));
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected bit", 1, 0);
      end else begin
        b = exp_q.pop_front();
        check(cd == b, "R3 bit value", int'(cd), int'(b));
      end
      run_len++;
    end else begin
      if (run_len > 0) last_run = run_len;
      run_len = 0;
    end
    prev_d = cd; prev_s = cs;
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk); #(CP/4); sample(1'b1);
      @(negedge clk); #(CP/4); sample(1'b0);
    end
  end

  // Driver: offer one character, push its bits once accepted.
  task automatic send_char(input logic [W-1:0] v);
    bit r;
    @(negedge clk);
    in_valid = 1'b1; in_data = v;
    forever begin
      #1; r = in_ready;
      @(posedge clk);
      if (r) begin
        acc_time = $time;
        for (int i = 0; i < W; i++) exp_q.push_back(v[i]);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic stop_send();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CP * 20000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int ev0;
    #(CP * 3 + 2);
    check(ds_data == 0 && ds_strobe == 0, "R1 wires in reset", {ds_data, ds_strobe}, 0);
    check(in_ready == 1, "R1 ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ds_data == 0 && ds_strobe == 0 && in_ready, "R1 after release",
          {ds_data, ds_strobe, in_ready}, 1);

    // Single character: latency, order, then idle hold.
    first_ev = 0;
    send_char(8'hA5);
    stop_send();
    check(in_ready == 0, "R2 busy ready low", in_ready, 0);
    repeat (8) @(negedge clk);
    check(first_ev - acc_time == 2 * CP + CP / 4, "R3 latency",
          int'(first_ev - acc_time), int'(2 * CP + CP / 4));
    #(CP/4);
    check(ds_data == 1 && ds_strobe == 1, "R7 idle low phase", {ds_data, ds_strobe}, 3);
    @(posedge clk); #(CP/4);
    check(ds_data == 1 && ds_strobe == 1, "R7 idle high phase", {ds_data, ds_strobe}, 3);

    // Back-to-back characters with uniform and mixed bits.
    send_char(8'h00);
    send_char(8'hFF);
    send_char(8'h3C);
    stop_send();
    repeat (20) @(negedge clk);
    check(last_run == 3 * W, "R6 continuous run", last_run, 3 * W);
    check(exp_q.size() == 0, "R3 all bits out", exp_q.size(), 0);

    // In_data toggling with valid low must send nothing.
    ev0 = events;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); in_data = W'(i * 37);
    end
    repeat (4) @(negedge clk);
    check(events == ev0, "R2 no send while invalid", events - ev0, 0);
    check(ds_data == 0 && ds_strobe == 0, "R7 hold after 3C", {ds_data, ds_strobe}, 0);

    // Resume after idle.
    send_char(8'h96);
    send_char(8'h01);
    stop_send();
    repeat (20) @(negedge clk);
    check(last_run == 2 * W, "R8 resume run", last_run, 2 * W);
    check(exp_q.size() == 0, "R8 all bits out", exp_q.size(), 0);
    finish_run();
  end

endmodule